// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Identification Serializer

This block sends a fixed 32-bit identification word on a serial data line after a reset pulse arrives while the device is selected. The block samples the chip select (active low), the reset pin, the serial clock and the bus data line in the system clock domain. It detects their edges there, so none of these pins is used as a clock. A busy flag from the nonvolatile write engine stops the response from starting.

A reset pulse arms the stream while chip select is low and no write is in progress. When reset falls, the block drives the line and presents the first bit. Each falling edge of the serial clock moves the stream on by one bit. The four identification bytes go out in the order 0x19, 0x00, 0xAA, 0x55, and each byte is sent least significant bit first. Once all 32 bits are out, the sequence starts again from the first byte.

Raising chip select ends the stream at once and returns the block to standby. A second reset pulse during the stream also releases the line. After that, the block stays quiet until a stop condition appears on the bus.

Top module: `atr_stream`

## Requirements
- R1: After system reset the line is released: `sda_oe` is 0 and `sda_out` is 1.
- R2: A reset pin pulse (high, then low) while `cs_n` is low and `nv_busy` is 0 arms the stream. After reset falls, `sda_oe` is 1 and `sda_out` carries bit 0 of the first byte.
- R3: A reset pin pulse while `cs_n` is high has no effect: `sda_oe` stays 0.
- R4: A reset pin rise while `nv_busy` is 1 is refused: `sda_oe` stays 0 after the pulse ends.
- R5: Stream bit k (counting from 0) is bit k%8 of byte k/8. The bytes are, in order, 0x19, 0x00, 0xAA, 0x55. The stream advances by one bit on each serial clock falling edge and never on a rising edge.
- R6: The falling edge after bit 31 brings back bit 0 of byte 0x19, and the sequence repeats without end.
- R7: Driving `cs_n` high during the stream sets `sda_oe` to 0. Lowering `cs_n` again does not resume the stream; only a new reset pulse does, and that stream starts at bit 0.
- R8: A reset pin rise during the stream sets `sda_oe` to 0. After that, serial clocks and further reset pulses leave the line released until a stop condition arrives.
- R9: A stop condition is `sda_in` rising while `scl` is high. It returns the block from the released-after-reset state to standby, and a later reset pulse arms it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| cs_n | input | 1 | Chip select pin, active low |
| rst_pin | input | 1 | Card reset pin, active high pulse |
| scl | input | 1 | Serial clock pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| nv_busy | input | 1 | Nonvolatile write cycle in progress |
| sda_out | output | 1 | Serial data value to drive |
| sda_oe | output | 1 | Drive enable for the data pin |

## Verification
The hardest state to reach from the ports is the one entered when reset is pulsed again during a stream. In that state the line stays released, yet the block must ignore both serial clocks and a third reset pulse. Only a stop condition built from `sda_in` and `scl` may leave it. The bench first drives a stream several bits deep, then pulses reset, then applies clocks and another reset pulse, and checks that the line stays released after each. Finally it sends a stop condition and confirms that a fresh pulse arms the stream again at bit 0.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_STREAM = 2'd2,
        ST_LOCK   = 2'd3
    } atr_state_e;
endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[g];
                s2_q <= RST_VAL[g];
                s3_q <= RST_VAL[g];
            end else begin
                s1_q <= pin_i[g];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign lvl_o[g]  = s2_q;
        assign rise_o[g] = s2_q & ~s3_q;
        assign fall_o[g] = ~s2_q & s3_q;
    end
endmodule

// File: rtl/atr_pattern.sv
module atr_pattern #(
    parameter int                  ATR_BITS = 32,
    parameter logic [ATR_BITS-1:0] ATR_WORD = 32'h55AA0019,
    localparam int                 IDX_W    = $clog2(ATR_BITS)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    // word bit k = byte k/8, bit k%8: low byte goes out first, LSB first
    assign bit_o = ATR_WORD[idx_i];
endmodule

// File: rtl/atr_stream.sv
module atr_stream #(
    parameter int                  ATR_BITS = 32,
    parameter logic [ATR_BITS-1:0] ATR_WORD = 32'h55AA0019,
    localparam int                 IDX_W    = $clog2(ATR_BITS),
    localparam logic [IDX_W-1:0]   IDX_LAST = IDX_W'(ATR_BITS - 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rst_pin,
    input  logic scl,
    input  logic sda_in,
    input  logic nv_busy,
    output logic sda_out,
    output logic sda_oe
);
    import atr_pkg::*;

    localparam int PIN_SCL = 0;
    localparam int PIN_RST = 1;
    localparam int PIN_CS  = 2;
    localparam int PIN_SDA = 3;

    typedef struct packed {
        atr_state_e       state;
        logic [IDX_W-1:0] idx;
    } atr_regs_t;

    logic [3:0] pin_lvl, pin_rise, pin_fall;
    logic       cs_hi, rst_rise, rst_fall, scl_fall, stop_seen;
    logic       pat_bit;
    atr_regs_t  d, q;

    atr_sync #(.N(4), .RST_VAL(4'b1100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sda_in, cs_n, rst_pin, scl}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign cs_hi     = pin_lvl[PIN_CS];
    assign rst_rise  = pin_rise[PIN_RST];
    assign rst_fall  = pin_fall[PIN_RST];
    assign scl_fall  = pin_fall[PIN_SCL];
    assign stop_seen = pin_rise[PIN_SDA] & pin_lvl[PIN_SCL];

    atr_pattern #(.ATR_BITS(ATR_BITS), .ATR_WORD(ATR_WORD)) u_pat (
        .idx_i (q.idx),
        .bit_o (pat_bit)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (!cs_hi && rst_rise && !nv_busy) d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_hi) begin
                    d.state = ST_IDLE;
                end else if (rst_fall) begin
                    d.state = ST_STREAM;
                    d.idx   = '0;
                end
            end
            ST_STREAM: begin
                if (cs_hi) begin
                    d.state = ST_IDLE;
                end else if (rst_rise) begin
                    d.state = ST_LOCK;
                end else if (scl_fall) begin
                    d.idx = (q.idx == IDX_LAST) ? '0 : q.idx + 1'b1;
                end
            end
            ST_LOCK: begin
                if (cs_hi || stop_seen) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, idx: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = (q.state == ST_STREAM);
    assign sda_out = sda_oe ? pat_bit : 1'b1;
endmodule

// File: rtl/atr_stream_chk.sv
module atr_stream_chk #(
    parameter int IDX_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input atr_pkg::atr_state_e  state,
    input logic [IDX_W-1:0]     idx,
    input logic                 cs_hi,
    input logic                 rst_rise,
    input logic                 scl_fall,
    input logic                 nv_busy,
    input logic                 sda_oe,
    input logic                 sda_out
);
    import atr_pkg::*;

    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && sda_out)); // R1

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rst_rise && nv_busy) |=> (state == ST_IDLE && !sda_oe)); // R4

    AST_NO_STRAY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !scl_fall && !cs_hi && !rst_rise) |=> $stable(idx)); // R5

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && idx == '1 && scl_fall && !cs_hi && !rst_rise) |=> (idx == '0)); // R6

    AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !sda_oe); // R7

    AST_REPULSE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && rst_rise && !cs_hi) |=> (state == ST_LOCK && !sda_oe)); // R8
endmodule

bind atr_stream atr_stream_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (q.state),
    .idx      (q.idx),
    .cs_hi    (cs_hi),
    .rst_rise (rst_rise),
    .scl_fall (scl_fall),
    .nv_busy  (nv_busy),
    .sda_oe   (sda_oe),
    .sda_out  (sda_out)
);

// File: tb/atr_stream_test.sv
module atr_stream_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rst_pin = 1'b0, scl = 1'b0, sda_in = 1'b1, nv_busy = 1'b0;
    logic sda_out, sda_oe;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    // expected identification bytes in transmit order, LSB first within each
    localparam logic [7:0] EXP_BYTES [4] = '{8'h19, 8'h00, 8'hAA, 8'h55};
    localparam int N_VEC = 40;

    always #10 clk = ~clk;

    atr_stream uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rst_pin(rst_pin), .scl(scl),
        .sda_in(sda_in), .nv_busy(nv_busy), .sda_out(sda_out), .sda_oe(sda_oe)
    );

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse_rst();
        rst_pin = 1'b1; settle();
        rst_pin = 1'b0; settle();
    endtask

    task automatic clk_pulse();
        scl = 1'b1; settle();
        scl = 1'b0; settle();
    endtask

    function automatic logic exp_bit(input int k);
        int m = k % 32;
        return EXP_BYTES[m / 8][m % 8];
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R1 oe", sda_oe, 1'b0);
        check("R1 data", sda_out, 1'b1);

        // R3: pulse while deselected
        pulse_rst();
        check("R3 deselected pulse", sda_oe, 1'b0);

        // R4: busy at the reset rise
        cs_n = 1'b0; settle();
        nv_busy = 1'b1; rst_pin = 1'b1; settle();
        nv_busy = 1'b0; rst_pin = 1'b0; settle();
        check("R4 busy refuses", sda_oe, 1'b0);

        // R2 arm, then R5/R6 table walk
        pulse_rst();
        check("R2 armed oe", sda_oe, 1'b1);
        check("R2 first bit", sda_out, exp_bit(0));
        for (int k = 1; k < N_VEC; k++) begin
            scl = 1'b1; settle();
            check("R5 no advance on rise", sda_out, exp_bit(k - 1));
            scl = 1'b0; settle();
            check((k % 32 == 0) ? "R6 wrap" : "R5 bit", sda_out, exp_bit(k));
            check("R5 oe held", sda_oe, 1'b1);
        end

        // R7: deselect aborts, reselect does not resume
        cs_n = 1'b1; settle();
        check("R7 abort oe", sda_oe, 1'b0);
        cs_n = 1'b0; settle();
        clk_pulse();
        check("R7 no resume", sda_oe, 1'b0);
        pulse_rst();
        check("R7 rearm oe", sda_oe, 1'b1);
        check("R7 restart bit0", sda_out, exp_bit(0));
        clk_pulse(); clk_pulse(); clk_pulse();
        check("R7 bit3", sda_out, exp_bit(3));

        // R8: second pulse releases, stays released
        pulse_rst();
        check("R8 repulse release", sda_oe, 1'b0);
        clk_pulse(); clk_pulse();
        check("R8 clocks ignored", sda_oe, 1'b0);
        pulse_rst();
        check("R8 pulse ignored", sda_oe, 1'b0);

        // R9: stop condition, then rearm
        sda_in = 1'b0; settle();
        scl = 1'b1; settle();
        sda_in = 1'b1; settle();
        scl = 1'b0; settle();
        check("R9 after stop idle", sda_oe, 1'b0);
        pulse_rst();
        check("R9 rearm oe", sda_oe, 1'b1);
        check("R9 rearm bit0", sda_out, exp_bit(0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule